// File: doc/BRIEF.md
# Clock-Master Synchronous Serial Transceiver

This block moves one byte out on a serial data line while it shifts one byte in, and it drives the serial clock itself. A transfer needs a byte on the parallel transmit port. If the flow-control gate is active, the clear-to-send input must also be low before the transfer starts. After the eighth bit the assembled receive byte appears on the parallel receive port, together with a one-cycle strobe.

Software sets the block up through three byte-wide registers:
- **Control register.** Chooses the bit-clock source, the clock polarity, the bit order, whether clear-to-send gates transmission, and a recorded pad drive type. It also shows a read-only transmit-empty flag.
- **Baud divisor register.** Sets how many source ticks make up each half of a bit.
- **Prescaler register.** Holds a 4-bit value n, an enable bit, and a sticky error flag that records writes of the reserved clock-source code.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset the control register reads 0x08, the divisor and prescaler registers read 0x00, sclk_o is high and rx_valid_o is low.
- R2: The control register (address 0) layout is:
  - bits [1:0]: clock source
  - bit 2: drive type, copied to od_mode_o
  - bit 3: transmit-empty flag, read-only (writes to it are ignored)
  - bit 4: flow select (0 = clear-to-send function)
  - bit 5: flow disable
  - bit 6: polarity
  - bit 7: MSB first

  All writable bits read back as written.
- R3: A control write whose source field is 11 leaves the source field unchanged and writes all other fields. It also sets bit 7 of the prescaler register (address 2), which stays set until reset.
- R4: The transmit-empty flag reads 0 from the cycle after a byte is accepted until its frame completes, then reads 1.
- R5: sclk_o idles at the inverse of the polarity bit. The leading edge moves to the polarity level and updates sdo_o. The trailing edge returns to idle and samples sdi_i. With polarity 0, data therefore changes on falling edges and is sampled on rising edges.
- R6: The 8 frame bits go out and come in LSB first when the order bit is 0 and MSB first when it is 1.
- R7: At frame end, rx_valid_o pulses for exactly one cycle with rx_data_o holding the received byte.
- R8: When flow disable and flow select are both 0, a frame starts only while cts_ni is low, and a started frame always completes. If either bit is 1, cts_ni has no effect.
- R9: Each half bit lasts (divisor+1) source ticks. Source 00 ticks every clock, source 01 ticks every 8 clocks, and source 10 ticks at the prescaler output. The prescaler output is every clock for n = 0 and every 2n clocks for n = 1..15; n sits in bits [3:0] of address 2.
- R10: With source 10 and the prescaler disabled (address 2 bit 4 = 0), no serial clock edges occur. A pending frame proceeds once the prescaler is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 control, 1 divisor, 2 prescaler) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | Load tx_data_i when no byte is pending |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe on frame completion |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| cts_ni | input | 1 | Clear-to-send, active low |
| od_mode_o | output | 1 | Recorded pad drive type |

## Verification
The assertions take for granted three things about the inputs:
- cts_ni is synchronous to clk_i.
- sdi_i is stable across the trailing edge of the serial clock.
- Configuration is not rewritten while a frame is in flight.

The stimulus respects all three. It writes registers only between frames, while the transmit-empty flag reads 1. It moves sdi_i only at the half-cycle after a leading edge, in the way a slave device would. It changes cts_ni only on falling clock edges.

// File: rtl/sser_pkg.sv
package sser_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    SRC_CLK  = 2'b00,
    SRC_DIV8 = 2'b01,
    SRC_PRE  = 2'b10,
    SRC_RSVD = 2'b11
  } src_e;

  typedef struct packed {
    logic msb_first;
    logic pol;
    logic flow_off;
    logic flow_sel;
    logic empty;
    logic od;
    src_e src;
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DIV  = 2'd1;
  localparam logic [1:0] ADDR_PRE  = 2'd2;
endpackage

// File: rtl/sser_regs.sv
module sser_regs
  import sser_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PRE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             tx_empty_i,
  output logic [REG_W-1:0] rdata_o,
  output src_e             src_o,
  output logic             pol_o,
  output logic             msb_first_o,
  output logic             flow_off_o,
  output logic             flow_sel_o,
  output logic             od_o,
  output logic [DIV_W-1:0] div_o,
  output logic [PRE_W-1:0] pre_n_o,
  output logic             pre_en_o
);
  ctrl_t            ctrl_q, ctrl_w, ctrl_rd;
  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_n_q;
  logic             pre_en_q, cfg_err_q;

  assign ctrl_w = ctrl_t'(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      div_q     <= '0;
      pre_n_q   <= '0;
      pre_en_q  <= 1'b0;
      cfg_err_q <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_CTRL: begin
          ctrl_q       <= ctrl_w;
          ctrl_q.empty <= 1'b0;
          if (ctrl_w.src == SRC_RSVD) begin
            ctrl_q.src <= ctrl_q.src;  // hold last legal source
            cfg_err_q  <= 1'b1;
          end
        end
        ADDR_DIV: div_q <= wdata_i[DIV_W-1:0];
        ADDR_PRE: begin
          pre_n_q  <= wdata_i[PRE_W-1:0];
          pre_en_q <= wdata_i[PRE_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctrl_rd       = ctrl_q;
    ctrl_rd.empty = tx_empty_i;
    rdata_o       = '0;
    case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_rd;
      ADDR_DIV:  rdata_o[DIV_W-1:0] = div_q;
      ADDR_PRE: begin
        rdata_o[PRE_W-1:0] = pre_n_q;
        rdata_o[PRE_W]     = pre_en_q;
        rdata_o[REG_W-1]   = cfg_err_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign src_o       = ctrl_q.src;
  assign pol_o       = ctrl_q.pol;
  assign msb_first_o = ctrl_q.msb_first;
  assign flow_off_o  = ctrl_q.flow_off;
  assign flow_sel_o  = ctrl_q.flow_sel;
  assign od_o        = ctrl_q.od;
  assign div_o       = div_q;
  assign pre_n_o     = pre_n_q;
  assign pre_en_o    = pre_en_q;

  // R3: reserved source code never becomes active
  a_r3_src_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.src != SRC_RSVD);

  // R3: error flag is sticky
  a_r3_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_q |=> cfg_err_q);
endmodule

// File: rtl/sser_tick_gen.sv
module sser_tick_gen
  import sser_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PRE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  src_e             src_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [PRE_W-1:0] pre_n_i,
  input  logic             pre_en_i,
  output logic             edge_tick_o
);
  localparam int PC_W = PRE_W + 1;

  logic [2:0]       c8_q;
  logic [PC_W-1:0]  pc_q, pre_lim;
  logic [DIV_W-1:0] bc_q;
  logic             div8_tick, pre_tick, src_tick;

  assign pre_lim   = {pre_n_i, 1'b0} - PC_W'(1);
  assign div8_tick = (c8_q == 3'd7);
  assign pre_tick  = pre_en_i && ((pre_n_i == '0) || (pc_q >= pre_lim));

  always_comb begin
    case (src_i)
      SRC_CLK:  src_tick = 1'b1;
      SRC_DIV8: src_tick = div8_tick;
      SRC_PRE:  src_tick = pre_tick;
      default:  src_tick = 1'b0;
    endcase
  end

  assign edge_tick_o = src_tick && (bc_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c8_q <= '0;
      pc_q <= '0;
      bc_q <= '0;
    end else begin
      c8_q <= c8_q + 3'd1;
      pc_q <= (!pre_en_i || pre_tick) ? '0 : pc_q + PC_W'(1);
      if (src_tick) bc_q <= edge_tick_o ? '0 : bc_q + DIV_W'(1);
    end
  end

  // R10: a disabled prescaler yields no serial edges
  a_r10_pre_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_PRE && !pre_en_i) |-> !edge_tick_o);
endmodule

// File: rtl/sser_shift_engine.sv
module sser_shift_engine #(
  parameter int FRAME_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               edge_tick_i,
  input  logic               pol_i,
  input  logic               msb_first_i,
  input  logic               gate_ok_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  input  logic               tx_valid_i,
  input  logic               sdi_i,
  output logic               sclk_o,
  output logic               sdo_o,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               rx_valid_o,
  output logic               tx_empty_o
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               busy_q, phase_q, pend_q, sclk_q, sdo_q, rx_valid_q;
  logic [CNT_W-1:0]   cnt_q, idx;
  logic [FRAME_W-1:0] buf_q, tx_sh_q, rx_sh_q, rx_next, rx_data_q;

  assign idx = msb_first_i ? (LAST - cnt_q) : cnt_q;

  always_comb begin
    rx_next      = rx_sh_q;
    rx_next[idx] = sdi_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      phase_q    <= 1'b0;
      pend_q     <= 1'b0;
      sclk_q     <= 1'b1;
      sdo_q      <= 1'b1;
      rx_valid_q <= 1'b0;
      cnt_q      <= '0;
      buf_q      <= '0;
      tx_sh_q    <= '0;
      rx_sh_q    <= '0;
      rx_data_q  <= '0;
    end else begin
      rx_valid_q <= 1'b0;
      if (tx_valid_i && !pend_q) begin
        pend_q <= 1'b1;
        buf_q  <= tx_data_i;
      end
      if (!busy_q) begin
        sclk_q <= ~pol_i;
        if (pend_q && gate_ok_i) begin
          busy_q  <= 1'b1;
          pend_q  <= 1'b0;
          tx_sh_q <= buf_q;
          cnt_q   <= '0;
          phase_q <= 1'b0;
        end
      end else if (edge_tick_i) begin
        if (!phase_q) begin
          // leading edge: launch bit
          sclk_q  <= pol_i;
          sdo_q   <= tx_sh_q[idx];
          phase_q <= 1'b1;
        end else begin
          // trailing edge: capture bit
          sclk_q  <= ~pol_i;
          rx_sh_q <= rx_next;
          phase_q <= 1'b0;
          if (cnt_q == LAST) begin
            busy_q     <= 1'b0;
            rx_valid_q <= 1'b1;
            rx_data_q  <= rx_next;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      end
    end
  end

  assign sclk_o     = sclk_q;
  assign sdo_o      = sdo_q;
  assign rx_data_o  = rx_data_q;
  assign rx_valid_o = rx_valid_q;
  assign tx_empty_o = !pend_q && !busy_q;

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_q |=> !rx_valid_q);

  a_r8_start_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(gate_ok_i));

  // R5: data line holds across the trailing edge
  a_r5_sdo_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && phase_q && edge_tick_i) |=> $stable(sdo_q));

  a_r4_busy_not_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !tx_empty_o);
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import sser_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int DIV_W   = 8,
  parameter int PRE_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic [FRAME_W-1:0] tx_data_i,
  input  logic               tx_valid_i,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               rx_valid_o,
  output logic               sclk_o,
  output logic               sdo_o,
  input  logic               sdi_i,
  input  logic               cts_ni,
  output logic               od_mode_o
);
  src_e             src;
  logic             pol, msb_first, flow_off, flow_sel, od;
  logic [DIV_W-1:0] div;
  logic [PRE_W-1:0] pre_n;
  logic             pre_en, edge_tick, tx_empty, gate_ok;

  sser_regs #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .tx_empty_i (tx_empty),
    .rdata_o    (reg_rdata_o),
    .src_o      (src),
    .pol_o      (pol),
    .msb_first_o(msb_first),
    .flow_off_o (flow_off),
    .flow_sel_o (flow_sel),
    .od_o       (od),
    .div_o      (div),
    .pre_n_o    (pre_n),
    .pre_en_o   (pre_en)
  );

  sser_tick_gen #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src),
    .div_i      (div),
    .pre_n_i    (pre_n),
    .pre_en_i   (pre_en),
    .edge_tick_o(edge_tick)
  );

  // CTS gates only with flow control enabled and CTS function selected
  assign gate_ok = flow_off | flow_sel | ~cts_ni;

  sser_shift_engine #(.FRAME_W(FRAME_W)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .edge_tick_i(edge_tick),
    .pol_i      (pol),
    .msb_first_i(msb_first),
    .gate_ok_i  (gate_ok),
    .tx_data_i  (tx_data_i),
    .tx_valid_i (tx_valid_i),
    .sdi_i      (sdi_i),
    .sclk_o     (sclk_o),
    .sdo_o      (sdo_o),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .tx_empty_o (tx_empty)
  );

  assign od_mode_o = od;
endmodule

// File: tb/sim_sync_serial_xcvr.sv
module sim_sync_serial_xcvr;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [7:0] reg_wdata_i = 8'd0;
  logic [7:0] reg_rdata_o;
  logic [7:0] tx_data_i = 8'd0;
  logic       tx_valid_i = 1'b0;
  logic [7:0] rx_data_o;
  logic       rx_valid_o;
  logic       sclk_o, sdo_o, od_mode_o;
  logic       sdi_i = 1'b0;
  logic       cts_ni = 1'b1;

  int checks = 0;
  int fails = 0;

  // bench-side configuration mirror
  logic       in_frame = 1'b0;
  logic       cur_pol = 1'b0;
  logic       cur_msb = 1'b0;
  logic [7:0] rx_pat = 8'd0;

  // monitor state
  logic       sclk_prev = 1'b1;
  int         lead_cnt = 0;
  int         trail_cnt = 0;
  int         edge_total = 0;
  int         cyc = 0;
  int         last_edge_cyc = 0;
  int         last_interval = 0;
  logic [7:0] cap_byte = 8'd0;

  always #2 clk_i = ~clk_i;

  sync_serial_xcvr u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .tx_data_i(tx_data_i),
    .tx_valid_i(tx_valid_i), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
    .sclk_o(sclk_o), .sdo_o(sdo_o), .sdi_i(sdi_i), .cts_ni(cts_ni), .od_mode_o(od_mode_o)
  );

  always @(posedge clk_i) cyc <= cyc + 1;

  // slave model: drive sdi after leading edges, capture sdo at trailing edges
  always @(negedge clk_i) begin
    if (in_frame && sclk_o != sclk_prev) begin
      edge_total    = edge_total + 1;
      last_interval = cyc - last_edge_cyc;
      last_edge_cyc = cyc;
      if (sclk_o == cur_pol) begin
        sdi_i    = cur_msb ? rx_pat[7 - (lead_cnt % 8)] : rx_pat[lead_cnt % 8];
        lead_cnt = lead_cnt + 1;
      end else begin
        if (cur_msb) cap_byte[7 - (trail_cnt % 8)] = sdo_o;
        else         cap_byte[trail_cnt % 8] = sdo_o;
        trail_cnt = trail_cnt + 1;
      end
    end
    sclk_prev = sclk_o;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic set_ctrl(input logic [7:0] c);
    reg_wr(2'd0, c);
    cur_pol = c[6];
    cur_msb = c[7];
  endtask

  task automatic send(input logic [7:0] tx, input logic [7:0] rxp);
    rx_pat   = rxp;
    in_frame = 1'b1;
    @(negedge clk_i);
    tx_data_i = tx; tx_valid_i = 1'b1;
    @(negedge clk_i);
    tx_valid_i = 1'b0;
  endtask

  task automatic wait_rx(input int limit, output logic seen);
    seen = 1'b0;
    for (int i = 0; i < limit && !seen; i++) begin
      @(negedge clk_i);
      if (rx_valid_o) seen = 1'b1;
    end
  endtask

  task automatic finish_frame(input string req, input logic [7:0] tx, input logic [7:0] rxp);
    logic seen;
    logic [7:0] v;
    wait_rx(6000, seen);
    check(seen, req, seen, 1);
    check(rx_data_o == rxp, "R6/R7 rx byte", rx_data_o, rxp);
    @(negedge clk_i);
    check(rx_valid_o == 1'b0, "R7 strobe one cycle", rx_valid_o, 0);
    check(cap_byte == tx, "R6 serial tx order", cap_byte, tx);
    check(sclk_o == ~cur_pol, "R5 idle level", sclk_o, ~cur_pol);
    in_frame = 1'b0;
    reg_rd(2'd0, v);
    check(v[3] == 1'b1, "R4 empty after frame", v[3], 1);
  endtask

  // ctrl, div, tx, rx, half-bit interval
  localparam logic [47:0] VEC [7] = '{
    {8'h20, 8'd0, 8'hA5, 8'h3C, 16'd1},
    {8'h60, 8'd2, 8'h81, 8'h7E, 16'd3},
    {8'hA0, 8'd1, 8'h0F, 8'hC3, 16'd2},
    {8'hE1, 8'd0, 8'h5A, 8'h96, 16'd8},
    {8'h24, 8'd0, 8'hFF, 8'h00, 16'd1},
    {8'h22, 8'd0, 8'h6B, 8'hD4, 16'd6},
    {8'h62, 8'd1, 8'h3E, 8'h71, 16'd12}
  };

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic seen;
    int e0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    reg_rd(2'd0, v); check(v == 8'h08, "R1 ctrl reset", v, 8'h08);
    reg_rd(2'd1, v); check(v == 8'h00, "R1 div reset", v, 0);
    reg_rd(2'd2, v); check(v == 8'h00, "R1 pre reset", v, 0);
    check(sclk_o == 1'b1, "R1 sclk idle", sclk_o, 1);
    check(rx_valid_o == 1'b0, "R1 rx_valid", rx_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    reg_rd(2'd0, v); check(v == 8'h08, "R1 ctrl after release", v, 8'h08);

    // R2 field readback, bit3 read-only
    set_ctrl(8'hF6);
    reg_rd(2'd0, v); check(v == 8'hFE, "R2 readback", v, 8'hFE);
    check(od_mode_o == 1'b1, "R2 od_mode", od_mode_o, 1);
    @(negedge clk_i);
    check(sclk_o == 1'b0, "R5 idle with pol 1", sclk_o, 0);

    reg_wr(2'd2, 8'h13);  // prescaler n=3 enabled
    reg_rd(2'd2, v); check(v == 8'h13, "R9 prescaler reg", v, 8'h13);

    // table walk: R5 R6 R7 R9 R4
    for (int k = 0; k < 7; k++) begin
      set_ctrl(VEC[k][47:40]);
      reg_wr(2'd1, VEC[k][39:32]);
      reg_rd(2'd0, v);
      check(v == (VEC[k][47:40] | 8'h08), "R2 ctrl vector", v, VEC[k][47:40] | 8'h08);
      check(od_mode_o == VEC[k][42], "R2 od vector", od_mode_o, VEC[k][42]);
      send(VEC[k][31:24], VEC[k][23:16]);
      reg_rd(2'd0, v);
      check(v[3] == 1'b0, "R4 empty while busy", v[3], 0);
      finish_frame("R7 frame done", VEC[k][31:24], VEC[k][23:16]);
      check(last_interval == int'(VEC[k][15:0]), "R9 half-bit interval",
            last_interval, VEC[k][15:0]);
    end

    // R3 reserved source
    set_ctrl(8'h21);
    reg_wr(2'd0, 8'h63);
    reg_rd(2'd0, v); check(v == 8'h69, "R3 source held", v, 8'h69);
    reg_rd(2'd2, v); check(v == 8'h93, "R3 error flag set", v, 8'h93);
    set_ctrl(8'h20);
    reg_rd(2'd2, v); check(v == 8'h93, "R3 error flag sticky", v, 8'h93);

    // R8 CTS gating
    set_ctrl(8'h00);
    reg_wr(2'd1, 8'd0);
    cts_ni = 1'b1;
    e0 = edge_total;
    send(8'hC6, 8'h29);
    repeat (50) @(negedge clk_i);
    check(edge_total == e0, "R8 blocked by cts", edge_total - e0, 0);
    reg_rd(2'd0, v); check(v[3] == 1'b0, "R4 pending while blocked", v[3], 0);
    cts_ni = 1'b0;
    finish_frame("R8 frame after cts", 8'hC6, 8'h29);

    send(8'h93, 8'hE8);
    repeat (4) @(negedge clk_i);
    cts_ni = 1'b1;
    finish_frame("R8 frame completes despite cts", 8'h93, 8'hE8);

    set_ctrl(8'h10);  // flow_sel=1: cts ignored
    send(8'h47, 8'hB2);
    finish_frame("R8 cts ignored flow_sel", 8'h47, 8'hB2);
    set_ctrl(8'h20);  // flow_off=1: cts ignored
    send(8'h1D, 8'h5C);
    finish_frame("R8 cts ignored flow_off", 8'h1D, 8'h5C);
    cts_ni = 1'b0;

    // R10 prescaler disabled
    reg_wr(2'd2, 8'h03);
    set_ctrl(8'h22);
    e0 = edge_total;
    send(8'hB7, 8'h4A);
    repeat (100) @(negedge clk_i);
    check(edge_total == e0, "R10 no edges when disabled", edge_total - e0, 0);
    check(sclk_o == 1'b1, "R10 sclk idle", sclk_o, 1);
    reg_wr(2'd2, 8'h10);  // enable, n=0: undivided
    wait_rx(2, seen);
    finish_frame("R10 frame after enable", 8'hB7, 8'h4A);
    check(last_interval == 1, "R9 prescaler n=0", last_interval, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule